// File: doc/BRIEF.md
# Hardwired Six-Step Instruction Control Sequencer

This block is the control unit of a small accumulator machine with one shared 8-bit bus. It takes the 4-bit operation code that the instruction register drives to it on dedicated wires, steps through a frame of timing states, and raises one enable line per datapath action in each state. The enables cover bus drive, register load, memory read and write, counter control, arithmetic selection and halting. Every instruction starts with the same two-state fetch: the program counter drives the address register, then memory loads the instruction register while the counter increments. The states after the fetch depend on the operation code.

The per-code sequences are fixed logic, not a stored table. By default every instruction takes all six states, and the states it does not need carry an all-zero control word. A parameter can instead send the sequencer back to the first state straight after the last state the instruction uses. When the halt line has been raised once, the sequencer freezes its state and keeps every enable low until it is reset.

Top module: `hw_step_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the timing state to T1 (`tstate` = 0) and clears the halted condition, both visible from the first clock edge that samples reset high.
- R2: `ctrl_word` bit positions are halt=0, addr_load=1, mem_write=2, mem_read=3, ir_drive=4, ir_load=5, acc_load=6, acc_drive=7, sum_drive=8, alu_sub=9, b_load=10, out_load=11, pc_inc=12, pc_drive=13, pc_load=14, flag_load=15. For every code, T1 raises only pc_drive and addr_load, and T2 raises only mem_read, ir_load and pc_inc.
- R3: Code 0x0 (load) raises ir_drive and addr_load in T3 and mem_read and acc_load in T4, and nothing in T5 or T6.
- R4: Code 0x1 (add) raises ir_drive and addr_load in T3, mem_read and b_load in T4, and sum_drive, acc_load and flag_load in T5, and nothing in T6.
- R5: Code 0x2 (subtract) matches code 0x1 in every state, except that alu_sub is also raised in T5.
- R6: Code 0xE (show) raises acc_drive and out_load in T3. Code 0xF (stop) raises only halt in T3. Neither code raises anything in T4 to T6.
- R7: After a cycle in which halt is raised, `tstate` stays at the value it had in that cycle and `ctrl_word` is zero, whatever `opcode` does, until reset.
- R8: Codes 0x3 to 0xD produce the two fetch states and a zero word in T3 to T6.
- R9: With EARLY_RETURN=0, `tstate` (0 to 5 for T1 to T6) advances by one on every rising edge and wraps from 5 to 0.
- R10: With EARLY_RETURN=1, the state after an instruction's last used state is T1. The last used state is T4 for code 0x0, T5 for codes 0x1 and 0x2, and T3 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Operation code from the instruction register |
| ctrl_word | output | 16 | Enable lines for the current state, bit positions as in R2 |
| tstate | output | 3 | Current timing state, 0 = T1 up to 5 = T6 |

## Verification
The state register drives `tstate` directly and the control word is decoded from it in the same cycle. A wrong step value therefore appears at both outputs in the cycle right after the bad edge: `tstate` is off, and the enables belong to another state. A stuck or lost halted condition appears one edge after the halt cycle, as a state that keeps moving or a word that is not zero. A wrong early-return choice appears as a T1 that comes too soon or too late at the end of the first instruction that uses it. The reference model predicts both outputs for every cycle, for both frame variants, across programs that mix all five codes with undefined codes and resets in the middle of an instruction.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    localparam int FRAME_LEN = 6;
    localparam int STEP_W    = $clog2(FRAME_LEN);
    localparam int OP_W      = 4;

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [OP_W-1:0]   opcode_t;

    localparam step_t S_T1   = STEP_W'(0);
    localparam step_t S_T2   = STEP_W'(1);
    localparam step_t S_T3   = STEP_W'(2);
    localparam step_t S_T4   = STEP_W'(3);
    localparam step_t S_T5   = STEP_W'(4);
    localparam step_t S_LAST = STEP_W'(FRAME_LEN - 1);

    localparam opcode_t OPC_LOAD = 4'h0;
    localparam opcode_t OPC_ADD  = 4'h1;
    localparam opcode_t OPC_SUB  = 4'h2;
    localparam opcode_t OPC_SHOW = 4'hE;
    localparam opcode_t OPC_STOP = 4'hF;

    // First member is the most significant bit: halt lands on bit 0.
    typedef struct packed {
        logic flag_load;
        logic pc_load;
        logic pc_drive;
        logic pc_inc;
        logic out_load;
        logic b_load;
        logic alu_sub;
        logic sum_drive;
        logic acc_drive;
        logic acc_load;
        logic ir_load;
        logic ir_drive;
        logic mem_read;
        logic mem_write;
        logic addr_load;
        logic halt;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Shared fetch: T1 and T2 are the same for every code.
    function automatic ctrl_t fetch_word(step_t s);
        ctrl_t w;
        w = '0;
        if (s == S_T1) begin
            w.pc_drive  = 1'b1;
            w.addr_load = 1'b1;
        end else if (s == S_T2) begin
            w.mem_read = 1'b1;
            w.ir_load  = 1'b1;
            w.pc_inc   = 1'b1;
        end
        return w;
    endfunction

    // Code-specific states T3..T6.
    function automatic ctrl_t exec_word(opcode_t op, step_t s);
        ctrl_t w;
        w = '0;
        unique case (op)
            OPC_LOAD, OPC_ADD, OPC_SUB: begin
                if (s == S_T3) begin
                    w.ir_drive  = 1'b1;
                    w.addr_load = 1'b1;
                end else if (s == S_T4) begin
                    w.mem_read = 1'b1;
                    if (op == OPC_LOAD) w.acc_load = 1'b1;
                    else                w.b_load   = 1'b1;
                end else if (s == S_T5 && op != OPC_LOAD) begin
                    w.sum_drive = 1'b1;
                    w.acc_load  = 1'b1;
                    w.flag_load = 1'b1;
                    w.alu_sub   = (op == OPC_SUB);
                end
            end
            OPC_SHOW: begin
                if (s == S_T3) begin
                    w.acc_drive = 1'b1;
                    w.out_load  = 1'b1;
                end
            end
            OPC_STOP: begin
                if (s == S_T3) w.halt = 1'b1;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

    // Last state an instruction uses (never earlier than T3: the code is
    // only valid once the fetch has completed).
    function automatic step_t final_step(opcode_t op);
        step_t s;
        unique case (op)
            OPC_LOAD:         s = S_T4;
            OPC_ADD, OPC_SUB: s = S_T5;
            default:          s = S_T3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/step_decoder.sv
module step_decoder
    import stepseq_pkg::*;
#(
    parameter bit EARLY_RETURN = 1'b0
) (
    input  opcode_t op,
    input  step_t   step,
    output ctrl_t   word,
    output logic    ret_now
);

    always_comb begin
        if (step == S_T1 || step == S_T2) word = fetch_word(step);
        else                              word = exec_word(op, step);
    end

    generate
        if (EARLY_RETURN) begin : g_early
            always_comb ret_now = (step == final_step(op));
        end else begin : g_full
            always_comb ret_now = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/step_counter.sv
module step_counter
    import stepseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  ret_now,
    output step_t step_q
);

    always_ff @(posedge clk) begin
        if (rst)                                step_q <= S_T1;
        else if (hold)                          step_q <= step_q;
        else if (ret_now || step_q == S_LAST)   step_q <= S_T1;
        else                                    step_q <= step_q + STEP_W'(1);
    end

    // R1
    reset_chk: assert property (@(posedge clk) rst |=> step_q == S_T1);

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && step_q == S_LAST) |=> step_q == S_T1);

    // R9
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !ret_now && step_q != S_LAST)
        |=> step_q == STEP_W'($past(step_q) + STEP_W'(1)));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(step_q));

endmodule

// File: rtl/halt_flag.sv
module halt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic halted
);

    always_ff @(posedge clk) begin
        if (rst)      halted <= 1'b0;
        else if (set) halted <= 1'b1;
    end

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R1
    clear_chk: assert property (@(posedge clk) rst |=> !halted);

endmodule

// File: rtl/hw_step_sequencer.sv
module hw_step_sequencer
    import stepseq_pkg::*;
#(
    parameter bit EARLY_RETURN = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  opcode,
    output logic [15:0] ctrl_word,
    output logic [2:0]  tstate
);

    step_t step_q;
    ctrl_t raw_word;
    ctrl_t out_word;
    logic  ret_now;
    logic  halted;
    logic  hold;

    step_decoder #(.EARLY_RETURN(EARLY_RETURN)) u_decode (
        .op      (opcode),
        .step    (step_q),
        .word    (raw_word),
        .ret_now (ret_now)
    );

    halt_flag u_halt (
        .clk    (clk),
        .rst    (rst),
        .set    (raw_word.halt),
        .halted (halted)
    );

    always_comb begin
        hold     = halted | raw_word.halt;
        out_word = halted ? '0 : raw_word;
    end

    step_counter u_count (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .ret_now (ret_now),
        .step_q  (step_q)
    );

    assign ctrl_word = out_word;
    assign tstate    = step_q;

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> ctrl_word == '0);

    // R2
    fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && tstate == S_T1) |-> ctrl_word == 16'h2002);

    generate
        if (EARLY_RETURN) begin : g_early_chk
            // R10
            early_ret_chk: assert property (@(posedge clk) disable iff (rst)
                (ret_now && !hold) |=> tstate == S_T1);
        end
    endgenerate

endmodule

// File: tb/hw_step_sequencer_tb.sv
module hw_step_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_f, op_s;
    logic [15:0] word_f, word_s;
    logic [2:0]  ts_f, ts_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hw_step_sequencer #(.EARLY_RETURN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .opcode(op_f), .ctrl_word(word_f), .tstate(ts_f));

    hw_step_sequencer #(.EARLY_RETURN(1'b1)) u_dut_short (
        .clk(clk), .rst(rst), .opcode(op_s), .ctrl_word(word_s), .tstate(ts_s));

    // Reference model state per instance (0 = full frame, 1 = early return)
    int         m_t   [2];
    bit         m_h   [2];
    logic [3:0] m_op  [2];
    int         m_idx [2];
    bit         last_rst;
    logic [3:0] prog  [10];

    assign op_f = m_op[0];
    assign op_s = m_op[1];

    function automatic int exp_word(logic [3:0] op, int t);
        int w = 0;
        if (t == 0) w = (1 << 13) | (1 << 1);
        else if (t == 1) w = (1 << 3) | (1 << 5) | (1 << 12);
        else if (op == 4'h0) begin
            if (t == 2) w = (1 << 4) | (1 << 1);
            if (t == 3) w = (1 << 3) | (1 << 6);
        end else if (op == 4'h1 || op == 4'h2) begin
            if (t == 2) w = (1 << 4) | (1 << 1);
            if (t == 3) w = (1 << 3) | (1 << 10);
            if (t == 4) w = (1 << 8) | (1 << 6) | (1 << 15) | ((op == 4'h2) ? (1 << 9) : 0);
        end else if (op == 4'hE) begin
            if (t == 2) w = (1 << 7) | (1 << 11);
        end else if (op == 4'hF) begin
            if (t == 2) w = 1;
        end
        return w;
    endfunction

    function automatic int last_used(logic [3:0] op);
        if (op == 4'h0) return 3;
        if (op == 4'h1 || op == 4'h2) return 4;
        return 2;
    endfunction

    function automatic string word_tag(int k);
        if (m_h[k]) return "R7";
        if (m_t[k] < 2) return "R2";
        case (m_op[k])
            4'h0: return "R3";
            4'h1: return "R4";
            4'h2: return "R5";
            4'hE, 4'hF: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check_dut(int k);
        logic [15:0] got_w = (k == 0) ? word_f : word_s;
        logic [2:0]  got_t = (k == 0) ? ts_f : ts_s;
        logic [15:0] ew = m_h[k] ? 16'h0 : 16'(exp_word(m_op[k], m_t[k]));
        string st = last_rst ? "R1" : ((k == 1) ? "R10" : "R9");
        checks++;
        if (got_t !== 3'(m_t[k])) begin
            errors++;
            $display("FAIL %s inst%0d tstate: actual %0d expected %0d", st, k, got_t, m_t[k]);
        end
        checks++;
        if (got_w !== ew) begin
            errors++;
            $display("FAIL %s inst%0d ctrl_word (op %h T%0d): actual %h expected %h",
                     word_tag(k), k, m_op[k], m_t[k] + 1, got_w, ew);
        end
    endtask

    task automatic advance(int k, int cyc);
        if (rst) begin
            m_t[k] = 0; m_h[k] = 1'b0; m_idx[k] = 0;
        end else if (m_h[k]) begin
            m_op[k] = 4'(cyc);          // R7: opcode churn must be ignored
        end else begin
            int w = exp_word(m_op[k], m_t[k]);
            if (m_t[k] == 1) begin
                m_op[k] = prog[m_idx[k]];
                if (m_idx[k] < 9) m_idx[k]++;
            end
            if (w[0]) m_h[k] = 1'b1;
            else if (m_t[k] == 5 || (k == 1 && m_t[k] >= 2 && m_t[k] == last_used(m_op[k])))
                m_t[k] = 0;
            else
                m_t[k]++;
        end
    endtask

    initial begin
        prog = '{4'h0, 4'h1, 4'h2, 4'hE, 4'h5, 4'h3, 4'h9, 4'h2, 4'h0, 4'hF};
        for (int k = 0; k < 2; k++) begin
            m_t[k] = 0; m_h[k] = 1'b0; m_op[k] = 4'h0; m_idx[k] = 0;
        end
        last_rst = 1'b1;
        for (int cyc = 0; cyc < 260; cyc++) begin
            @(negedge clk);
            check_dut(0);
            check_dut(1);
            last_rst = rst;
            rst = (cyc < 2) || (cyc >= 30 && cyc < 32) || (cyc >= 150 && cyc < 152);
            advance(0, cyc);
            advance(1, cyc);
            if (rst) last_rst = 1'b1;
            else last_rst = 1'b0;
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule